// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block recovers a card-to-reader response whose length the reader already knows. The card's load-modulated subcarrier arrives as a single sliced logic level. The block does not use a correlator. It counts the level changes inside fixed time windows, and a window with roughly the number of changes a subcarrier burst produces decodes as a one. The response has no start mark, no stop mark and no length field. Framing therefore comes from the reader's own timing: a start strobe marks the end of the reader frame, and the first bit window opens after a fixed turnaround delay. Later windows follow back to back.

A keystream word, computed elsewhere, may be loaded at the start strobe. Each decoded one then flips the matching keystream bit, so the delivered word is already decrypted. A card sending only zeros looks the same as no card, so the block makes no presence decision. It always delivers a word after the expected number of windows.

The controller has three states. IDLE waits for a strobe. TURN waits out the turnaround. WIN counts edges window by window. Its transitions are:
- start, which moves from any state into TURN;
- turnaround-over, which moves from TURN to WIN, or from TURN to IDLE when zero bits are requested;
- last-window-closed, which moves from WIN to IDLE.

Top module: `subcarrier_edge_rx`

## Requirements
- R1: After reset, `done` is 0 and `rx_word` is all zeros.
- R2: The sliced input passes through a two-flop synchroniser. Edges that occur before the turnaround has elapsed are ignored. The turnaround lasts TURN_TICKS ticks, counted from the start strobe, and one tick is TICK_DIV clock cycles.
- R3: The bit windows are contiguous. Each lasts WIN_TICKS ticks. Window k decides bit k of `rx_word`, so bit 0 is received first.
- R4: A window decodes as 1 exactly when its edge count is greater than EDGE_LO and less than EDGE_HI. Any other count, including zero, decodes as 0. The count saturates at EDGE_HI.
- R5: When `decrypt` is 1 at the start strobe, `rx_word` equals the received bits XOR `keystream`. When `decrypt` is 0, `rx_word` holds the received bits unchanged.
- R6: A requested bit count above MAX_BITS is clamped to MAX_BITS. Bit positions at or above the effective count are 0 in `rx_word`.
- R7: `done` is a single-cycle pulse. It is high in the clock cycle right after the edge that closes the last window.
- R8: `rx_word` changes only together with a `done` pulse. It keeps its value through the next reception until that reception completes.
- R9: A start strobe during a reception abandons that reception without a `done` pulse and restarts timing from the new strobe.
- R10: With a bit count of 0, `done` pulses one cycle after the turnaround ends and `rx_word` becomes all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slice_in | input | 1 | Sliced subcarrier level, asynchronous |
| start | input | 1 | One-cycle strobe at the end of the reader frame |
| nbits | input | NBITS_W | Number of response bits expected |
| decrypt | input | 1 | Preload the keystream into the result |
| keystream | input | MAX_BITS | Precomputed keystream word, LSB for bit 0 |
| rx_word | output | MAX_BITS | Decoded response word |
| done | output | 1 | Pulse marking that rx_word was updated |

## Verification
The bench builds the block with TICK_DIV=2, TURN_TICKS=12, WIN_TICKS=20, EDGE_LO=5 and EDGE_HI=15. With these values a window is 40 cycles, so a full 32-bit reception stays short, and the prescaler still divides rather than passing every clock. The small thresholds let directed windows sit exactly on the 5/6 and 14/15 boundaries, and a burst of 30 edges pushes the counter into saturation. Edges are also injected during the turnaround to show they are not counted.

// File: rtl/serx_pkg.sv
package serx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_WIN  = 2'd2
    } serx_state_t;
endpackage

// File: rtl/serx_sync_edge.sv
module serx_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_pulse
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign edge_pulse = sync_q ^ prev_q;
endmodule

// File: rtl/serx_tick_gen.sv
module serx_tick_gen #(
    parameter int TICK_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] PLAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= (pre_q == PLAST) ? '0 : pre_q + 1'b1;
        end
    end

    assign tick = run && (pre_q == PLAST);

    // R3: the prescaler never leaves its range
    assert_pre_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PLAST);
endmodule

// File: rtl/serx_edge_counter.sv
module serx_edge_counter #(
    parameter int EDGE_LO = 20,
    parameter int EDGE_HI = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic edge_pulse,
    output logic hit
);
    localparam int CW = $clog2(EDGE_HI + 1);
    localparam logic [CW-1:0] CMAX = CW'(EDGE_HI);
    localparam logic [CW-1:0] CMIN = CW'(EDGE_LO);

    logic [CW-1:0] cnt_q, cnt_eff;

    always_comb begin
        cnt_eff = cnt_q;
        if (en && edge_pulse && (cnt_q != CMAX)) cnt_eff = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else          cnt_q <= cnt_eff;
    end

    assign hit = (cnt_eff > CMIN) && (cnt_eff < CMAX);

    // R4: the count saturates and never wraps
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CMAX);
    // R4: each window starts from an empty count
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/subcarrier_edge_rx.sv
module subcarrier_edge_rx #(
    parameter int TICK_DIV   = 16,
    parameter int TURN_TICKS = 490,
    parameter int WIN_TICKS  = 150,
    parameter int EDGE_LO    = 20,
    parameter int EDGE_HI    = 60,
    parameter int MAX_BITS   = 32,
    parameter int NBITS_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slice_in,
    input  logic                start,
    input  logic [NBITS_W-1:0]  nbits,
    input  logic                decrypt,
    input  logic [MAX_BITS-1:0] keystream,
    output logic [MAX_BITS-1:0] rx_word,
    output logic                done
);
    import serx_pkg::*;

    localparam int TMAX = (TURN_TICKS > WIN_TICKS) ? TURN_TICKS : WIN_TICKS;
    localparam int TCW  = $clog2(TMAX + 1);
    localparam int BIW  = $clog2(MAX_BITS + 1);

    serx_state_t         state, state_nx;
    logic                tick, edge_pulse, hit;
    logic [TCW-1:0]      tcnt;
    logic [BIW-1:0]      bit_idx, n_q, n_clamp;
    logic [MAX_BITS-1:0] acc, acc_upd, mask;
    logic                turn_close, win_close, last_bit;

    // Clamp the requested length and build the valid-bit mask
    always_comb begin
        n_clamp = (32'(nbits) > MAX_BITS) ? BIW'(MAX_BITS) : BIW'(nbits);
        for (int i = 0; i < MAX_BITS; i++) begin
            mask[i] = (BIW'(i) < n_clamp);
        end
    end

    serx_sync_edge u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(slice_in), .edge_pulse(edge_pulse)
    );

    serx_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(start),
        .run(state != ST_IDLE), .tick(tick)
    );

    serx_edge_counter #(.EDGE_LO(EDGE_LO), .EDGE_HI(EDGE_HI)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start | win_close),
        .en(state == ST_WIN), .edge_pulse(edge_pulse), .hit(hit)
    );

    assign turn_close = (state == ST_TURN) && tick && (tcnt == TCW'(TURN_TICKS - 1));
    assign win_close  = (state == ST_WIN)  && tick && (tcnt == TCW'(WIN_TICKS - 1));
    assign last_bit   = (bit_idx == n_q - 1'b1);
    assign acc_upd    = acc ^ ({{(MAX_BITS-1){1'b0}}, hit} << bit_idx);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (start) begin
            state_nx = ST_TURN;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_TURN: if (turn_close) state_nx = (n_q == '0) ? ST_IDLE : ST_WIN;
                ST_WIN:  if (win_close && last_bit) state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Timing counter, bit index and accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt    <= '0;
            bit_idx <= '0;
            n_q     <= '0;
            acc     <= '0;
        end else if (start) begin
            tcnt    <= '0;
            bit_idx <= '0;
            n_q     <= n_clamp;
            acc     <= decrypt ? (keystream & mask) : '0;
        end else if (tick && (state != ST_IDLE)) begin
            if (turn_close || win_close) tcnt <= '0;
            else                         tcnt <= tcnt + 1'b1;
            if (win_close) begin
                acc     <= acc_upd;
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            rx_word <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                done <= 1'b0;
            end else if (win_close && last_bit) begin
                done    <= 1'b1;
                rx_word <= acc_upd;
            end else if (turn_close && (n_q == '0)) begin
                done    <= 1'b1;
                rx_word <= '0;
            end
        end
    end

    // R7: done is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: the result changes only together with done
    assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_word) |-> done);
    // R6: the bit index stays below the clamped length while receiving
    assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WIN) |-> (bit_idx < n_q));
    // R6: the effective length never exceeds the word width
    assert_len_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        n_q <= BIW'(MAX_BITS));
    // R9: a strobe always restarts the turnaround
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_TURN) && !done);
endmodule

// File: tb/sim_subcarrier_edge_rx.sv
module sim_subcarrier_edge_rx;
    localparam int TD = 2, TT_T = 12, WW_T = 20, LO = 5, HI = 15;
    localparam int TT = TD * TT_T;
    localparam int WW = TD * WW_T;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slice_in = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  nbits = '0;
    logic        decrypt = 1'b0;
    logic [31:0] keystream = '0;
    logic [31:0] rx_word;
    logic        done;

    int total = 0, bad = 0;
    int cnts[32];
    logic [31:0] last_word = '0;

    always #4 clk = ~clk;

    subcarrier_edge_rx #(
        .TICK_DIV(TD), .TURN_TICKS(TT_T), .WIN_TICKS(WW_T),
        .EDGE_LO(LO), .EDGE_HI(HI), .MAX_BITS(32), .NBITS_W(6)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .slice_in(slice_in), .start(start),
        .nbits(nbits), .decrypt(decrypt), .keystream(keystream),
        .rx_word(rx_word), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input int n, input bit dec, input logic [31:0] key);
        logic [31:0] w = '0;
        for (int i = 0; i < n; i++) begin
            w[i] = ((cnts[i] > LO) && (cnts[i] < HI)) ^ (dec & key[i]);
        end
        return w;
    endfunction

    // Runs one reception from the current negedge. abort_j > 0 stops early.
    task automatic run_frame(input int nin, input bit dec, input logic [31:0] key, input int abort_j);
        int n = (nin > 32) ? 32 : nin;
        int len = TT + n * WW;
        logic [31:0] exp = expect_word(n, dec, key);
        nbits = 6'(nin); decrypt = dec; keystream = key; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 1; j <= len; j++) begin
            int r = j + 1 - TT;
            if (r < 0) begin
                if ((j % 3) == 0) slice_in = ~slice_in;   // R2 noise in turnaround
            end else if ((r / WW) < n) begin
                int off = r % WW;
                if (off >= 4 && off < 4 + cnts[r / WW]) slice_in = ~slice_in;
            end
            if (j == len / 2 + 1) begin
                check(rx_word == last_word, "R8 word held", rx_word, last_word);
                check(done == 1'b0, "R8 no early done", 32'(done), 32'd0);
            end
            if (abort_j > 0 && j == abort_j) begin
                check(done == 1'b0, "R9 aborted no done", 32'(done), 32'd0);
                return;
            end
            @(negedge clk);
        end
        check(done == 1'b1, "R7 done pulse", 32'(done), 32'd1);
        check(rx_word == exp, (n == 0) ? "R10 empty word" : "R3 R4 R5 R6 word", rx_word, exp);
        last_word = rx_word;
        @(negedge clk);
        check(done == 1'b0, "R7 single cycle", 32'(done), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 reset done", 32'(done), 32'd0);
        check(rx_word == '0, "R1 reset word", rx_word, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 threshold boundaries, LSB first: expect 0x1C
        cnts[0] = 0; cnts[1] = 5; cnts[2] = 6; cnts[3] = 10;
        cnts[4] = 14; cnts[5] = 15; cnts[6] = 30; cnts[7] = 1;
        run_frame(8, 1'b0, 32'hDEAD_BEEF, 0);
        check(rx_word == 32'h0000_001C, "R4 boundary", rx_word, 32'h1C);
        // R5 R6 keystream XOR with masking above length: expect 0xE3
        run_frame(8, 1'b1, 32'hFFFF_FFFF, 0);
        check(rx_word == 32'h0000_00E3, "R5 R6 masked xor", rx_word, 32'hE3);
        // R2 turnaround noise only, zero windows: expect 0
        for (int i = 0; i < 32; i++) cnts[i] = 0;
        run_frame(4, 1'b0, 32'h0, 0);
        // R10 zero-length request
        run_frame(0, 1'b1, 32'hFFFF_FFFF, 0);
        // R3 single bit
        cnts[0] = 10;
        run_frame(1, 1'b0, 32'h0, 0);
        // R6 clamp above 32
        for (int i = 0; i < 32; i++) cnts[i] = $urandom_range(0, 30);
        run_frame(40, 1'b1, $urandom, 0);
        // R9 abort mid-frame, then a full frame
        run_frame(10, 1'b0, 32'h0, TT + 3 * WW);
        for (int i = 0; i < 32; i++) cnts[i] = $urandom_range(0, 30);
        run_frame(12, 1'b1, 32'h0F0F_A5A5, 0);
        // Random frames
        for (int f = 0; f < 14; f++) begin
            for (int i = 0; i < 32; i++) cnts[i] = $urandom_range(0, 30);
            run_frame($urandom_range(1, 40), 1'($urandom_range(0, 1)), $urandom, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule